// File: doc/BRIEF.md
# Ranked Best-Three Candidate Sorter

This block takes trigger candidates from nine upstream sources. Each source offers up to two candidates per crossing, so eighteen candidates arrive together. Every candidate is a 32-bit word sent as two 16-bit frames on a clock that runs at twice the crossing rate. The block rebuilds the words and ranks them on their 4-bit quality field. It then sends the three best candidates, best first, on three output links. Each link carries the winning word as two frames, in the same framing used at the input.

Together with the links, the block returns a winner mask to the sources. The mask has one bit per candidate slot and shows which candidates were chosen. A mode input cuts the search down to the first eight sources, so the block picks the best two of sixteen. In that mode the third link stays quiet.

The sorter is a fixed pipeline of four fast-clock cycles. It takes a fresh set of eighteen candidates on every crossing, which is every two fast-clock cycles.

Top module: `best3_sorter`

## Requirements
- R1: A crossing is a cycle with `frame_first` high followed by a cycle with `frame_first` low. In the first of these cycles, slice k of `cand_frames` (bits 16k+15..16k) carries bits 31..16 of candidate k. In the second cycle the same slice carries bits 15..0. Candidate k = 2*source + sub-index.
- R2: A candidate takes part only when its quality, bits 31..28 of its word, is nonzero. A zero-quality candidate never wins, whatever its other bits are.
- R3: Link slot 0 (bits 15..0 of `link_frames`) carries the highest-quality candidate, slot 1 the next and slot 2 the third. Each slot carries the candidate's full word.
- R4: Among candidates of equal quality, the lower candidate index ranks higher. This means the lower source first, then the lower sub-index.
- R5: A link slot with no winner outputs zero in both of its frames.
- R6: Each link sends its high half in the cycle where `link_first` is high and its low half in the next cycle. The high half appears in the fourth cycle after the cycle that carried the input high half.
- R7: Bit k of `win_bits` is set exactly when candidate k fills a link slot. The mask changes in the cycle `link_first` rises and holds until the next result.
- R8: `reduced_mode` is sampled together with the input high half. When it is high, source 8 (candidates 16 and 17) is ignored, its mask bits stay zero, slot 2 is zero, and only two winners are chosen.
- R9: Crossings may follow each other with no gap. Each one produces its own result, and results do not mix.
- R10: Synchronous reset clears the links, `link_first` and the mask, and throws away any crossing still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-rate clock (two cycles per crossing) |
| rst | input | 1 | Synchronous active-high reset |
| frame_first | input | 1 | High in the cycle that carries the high halves |
| reduced_mode | input | 1 | 1 = best two of the first sixteen candidates |
| cand_frames | input | 288 | One 16-bit frame per candidate, candidate k at bits 16k+15..16k |
| link_frames | output | 48 | One 16-bit frame per output slot, slot 0 in the low bits |
| link_first | output | 1 | High while the links carry the high halves |
| win_bits | output | 18 | Winner mask, bit k for candidate k |

## Verification
The stimulus set is built to separate different kinds of failure:
- An empty set and a single candidate check that zero quality excludes a candidate and that empty slots stay zero.
- A set with well-separated qualities checks that ranking follows quality and not position.
- Sets full of ties, including four candidates sharing the top quality, show whether the tie order follows candidate index.
- One quality pattern is sent in both modes, together with sets where only source 8 holds candidates, to show that the reduced mode really removes that source and the third slot.
- All sets run back to back to expose any mixing between crossings.
- Separate isolated runs pin down the four-cycle output timing, how long the mask is held, and reset during a crossing in flight.

// File: rtl/best3_pkg.sv
`timescale 1ns/1ps
package best3_pkg;
  typedef enum logic {
    SORT_FULL    = 1'b0,
    SORT_REDUCED = 1'b1
  } sort_mode_e;
endpackage

// File: rtl/b3_frame_assembler.sv
`timescale 1ns/1ps
// Rebuilds full candidate words from high/low frame pairs.
module b3_frame_assembler #(
  parameter int NTOT    = 18,
  parameter int FRAME_W = 16,
  localparam int WORD_W = 2 * FRAME_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_first,
  input  logic                      mode_in,
  input  logic [NTOT*FRAME_W-1:0]   frames_in,
  output logic [NTOT*WORD_W-1:0]    words_out,
  output logic                      mode_out,
  output logic                      words_vld
);
  logic                    hi_seen;
  logic [NTOT*FRAME_W-1:0] hi_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_seen   <= 1'b0;
      hi_hold   <= '0;
      mode_out  <= 1'b0;
      words_vld <= 1'b0;
      words_out <= '0;
    end else begin
      words_vld <= 1'b0;
      if (frame_first) begin
        hi_seen  <= 1'b1;
        hi_hold  <= frames_in;
        mode_out <= mode_in;
      end else if (hi_seen) begin
        hi_seen   <= 1'b0;
        words_vld <= 1'b1;
        for (int i = 0; i < NTOT; i++)
          words_out[i*WORD_W +: WORD_W] <= {hi_hold[i*FRAME_W +: FRAME_W],
                                            frames_in[i*FRAME_W +: FRAME_W]};
      end
    end
  end
endmodule

// File: rtl/b3_rank_select.sv
`timescale 1ns/1ps
// Ranks all candidates in parallel and routes the winners to slots.
module b3_rank_select
  import best3_pkg::*;
#(
  parameter int NTOT    = 18,
  parameter int PER_SRC = 2,
  parameter int WORD_W  = 32,
  parameter int QUAL_W  = 4,
  parameter int NOUT    = 3,
  localparam int RANK_W = $clog2(NTOT + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NTOT*WORD_W-1:0]   words_in,
  input  logic                     words_vld,
  input  logic                     mode_in,
  output logic [NOUT*WORD_W-1:0]   slot_words,
  output logic [NTOT-1:0]          win_out,
  output logic                     sel_vld
);
  logic                reduced;
  logic [RANK_W-1:0]   n_win;
  logic [QUAL_W-1:0]   qual [NTOT];
  logic [NTOT-1:0]     live;
  logic [RANK_W-1:0]   rank [NTOT];

  assign reduced = (sort_mode_e'(mode_in) == SORT_REDUCED);
  assign n_win   = reduced ? RANK_W'(NOUT - 1) : RANK_W'(NOUT);

  always_comb begin
    for (int i = 0; i < NTOT; i++) begin
      qual[i] = words_in[i*WORD_W + WORD_W - QUAL_W +: QUAL_W];
      live[i] = (qual[i] != '0) && !(reduced && (i >= NTOT - PER_SRC));
    end
  end

  // rank = number of live candidates that beat this one
  always_comb begin
    for (int i = 0; i < NTOT; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NTOT; j++) begin
        if (j != i && live[j] &&
            ((qual[j] > qual[i]) || ((qual[j] == qual[i]) && (j < i))))
          rank[i] = rank[i] + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NOUT; s++) begin : g_slot
    logic [WORD_W-1:0] pick;
    logic [WORD_W-1:0] slot_r;

    always_comb begin
      pick = '0;
      for (int i = 0; i < NTOT; i++)
        if (live[i] && (rank[i] == RANK_W'(s)))
          pick = pick | words_in[i*WORD_W +: WORD_W];
      if (RANK_W'(s) >= n_win)
        pick = '0;
    end

    always_ff @(posedge clk) begin
      if (rst)            slot_r <= '0;
      else if (words_vld) slot_r <= pick;
    end

    assign slot_words[s*WORD_W +: WORD_W] = slot_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_out <= '0;
      sel_vld <= 1'b0;
    end else begin
      sel_vld <= words_vld;
      if (words_vld)
        for (int i = 0; i < NTOT; i++)
          win_out[i] <= live[i] && (rank[i] < n_win);
    end
  end
endmodule

// File: rtl/b3_link_serializer.sv
`timescale 1ns/1ps
// Splits winner words back into high/low frames for the links.
module b3_link_serializer #(
  parameter int NOUT    = 3,
  parameter int FRAME_W = 16,
  parameter int NTOT    = 18,
  localparam int WORD_W = 2 * FRAME_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NOUT*WORD_W-1:0]   slot_words,
  input  logic                     sel_vld,
  input  logic [NTOT-1:0]          win_in,
  output logic [NOUT*FRAME_W-1:0]  link_frames,
  output logic                     link_first,
  output logic [NTOT-1:0]          win_out
);
  logic [NOUT*FRAME_W-1:0] hi_cat, lo_cat, lo_hold;

  always_comb begin
    for (int s = 0; s < NOUT; s++) begin
      hi_cat[s*FRAME_W +: FRAME_W] = slot_words[s*WORD_W + FRAME_W +: FRAME_W];
      lo_cat[s*FRAME_W +: FRAME_W] = slot_words[s*WORD_W +: FRAME_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_frames <= '0;
      lo_hold     <= '0;
      link_first  <= 1'b0;
      win_out     <= '0;
    end else begin
      link_first <= sel_vld;
      if (sel_vld) begin
        link_frames <= hi_cat;
        lo_hold     <= lo_cat;
        win_out     <= win_in;
      end else if (link_first) begin
        link_frames <= lo_hold;
      end
    end
  end
endmodule

// File: rtl/best3_sorter.sv
`timescale 1ns/1ps
module best3_sorter #(
  parameter int NSRC    = 9,
  parameter int NCAND   = 2,
  parameter int FRAME_W = 16,
  parameter int QUAL_W  = 4,
  parameter int NOUT    = 3,
  localparam int NTOT   = NSRC * NCAND,
  localparam int WORD_W = 2 * FRAME_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_first,
  input  logic                      reduced_mode,
  input  logic [NTOT*FRAME_W-1:0]   cand_frames,
  output logic [NOUT*FRAME_W-1:0]   link_frames,
  output logic                      link_first,
  output logic [NTOT-1:0]           win_bits
);
  logic [NTOT*WORD_W-1:0] words;
  logic                   words_vld, mode_q;
  logic [NOUT*WORD_W-1:0] slot_words;
  logic [NTOT-1:0]        win_sel;
  logic                   sel_vld;

  b3_frame_assembler #(.NTOT(NTOT), .FRAME_W(FRAME_W)) u_asm (
    .clk(clk), .rst(rst), .frame_first(frame_first), .mode_in(reduced_mode),
    .frames_in(cand_frames), .words_out(words), .mode_out(mode_q),
    .words_vld(words_vld)
  );

  b3_rank_select #(.NTOT(NTOT), .PER_SRC(NCAND), .WORD_W(WORD_W),
                   .QUAL_W(QUAL_W), .NOUT(NOUT)) u_rank (
    .clk(clk), .rst(rst), .words_in(words), .words_vld(words_vld),
    .mode_in(mode_q), .slot_words(slot_words), .win_out(win_sel),
    .sel_vld(sel_vld)
  );

  b3_link_serializer #(.NOUT(NOUT), .FRAME_W(FRAME_W), .NTOT(NTOT)) u_ser (
    .clk(clk), .rst(rst), .slot_words(slot_words), .sel_vld(sel_vld),
    .win_in(win_sel), .link_frames(link_frames), .link_first(link_first),
    .win_out(win_bits)
  );
endmodule

// File: rtl/best3_sorter_chk.sv
`timescale 1ns/1ps
module best3_sorter_chk #(
  parameter int NSRC    = 9,
  parameter int NCAND   = 2,
  parameter int FRAME_W = 16,
  parameter int QUAL_W  = 4,
  parameter int NOUT    = 3,
  localparam int NTOT   = NSRC * NCAND
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     frame_first,
  input logic                     reduced_mode,
  input logic [NOUT*FRAME_W-1:0]  link_frames,
  input logic                     link_first,
  input logic [NTOT-1:0]          win_bits
);
  logic [3:0] ff_hist, md_hist;
  int         filled;

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_hist <= '0;
      md_hist <= '0;
    end else begin
      ff_hist <= {ff_hist[2:0], frame_first};
      md_hist <= {md_hist[2:0], reduced_mode};
    end
  end

  always_comb begin
    filled = 0;
    for (int s = 0; s < NOUT; s++)
      if (link_frames[s*FRAME_W + FRAME_W - QUAL_W +: QUAL_W] != '0)
        filled = filled + 1;
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    link_first == (ff_hist[3] && !ff_hist[2]));

  assert_win_limit_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(win_bits) <= NOUT);

  assert_win_match_R7: assert property (@(posedge clk) disable iff (rst)
    link_first |-> ($countones(win_bits) == filled));

  assert_reduced_R8: assert property (@(posedge clk) disable iff (rst)
    (link_first && md_hist[3]) |->
      ((win_bits[NTOT-1 -: NCAND] == '0) &&
       (link_frames[(NOUT-1)*FRAME_W +: FRAME_W] == '0)));

  for (genvar s = 0; s < NOUT; s++) begin : g_slot_chk
    assert_empty_slot_R5: assert property (@(posedge clk) disable iff (rst)
      (link_first && (link_frames[s*FRAME_W + FRAME_W - QUAL_W +: QUAL_W] == '0))
        |=> (link_frames[s*FRAME_W +: FRAME_W] == '0));
    if (s < NOUT - 1) begin : g_order
      assert_rank_order_R3: assert property (@(posedge clk) disable iff (rst)
        link_first |->
          (link_frames[s*FRAME_W + FRAME_W - QUAL_W +: QUAL_W] >=
           link_frames[(s+1)*FRAME_W + FRAME_W - QUAL_W +: QUAL_W]));
    end
  end
endmodule

bind best3_sorter best3_sorter_chk #(
  .NSRC(NSRC), .NCAND(NCAND), .FRAME_W(FRAME_W), .QUAL_W(QUAL_W), .NOUT(NOUT)
) u_chk (
  .clk(clk), .rst(rst), .frame_first(frame_first), .reduced_mode(reduced_mode),
  .link_frames(link_frames), .link_first(link_first), .win_bits(win_bits)
);

// File: tb/sim_best3_sorter.sv
`timescale 1ns/1ps
module sim_best3_sorter;
  localparam int NSRC = 9, NCAND = 2, FW = 16, QW = 4, NOUT = 3;
  localparam int NTOT = NSRC * NCAND;
  localparam int NV = 11;
  // {mode, qualities cand17..cand0 (one hex digit each), slot0, slot1, slot2 index; 31 = empty}
  localparam logic [87:0] VEC [NV] = '{
    {1'b0, 72'h000000000000000000, 5'd31, 5'd31, 5'd31},
    {1'b0, 72'h000000000000000001, 5'd0,  5'd31, 5'd31},
    {1'b0, 72'hD0000E000000F02000, 5'd5,  5'd12, 5'd17},
    {1'b0, 72'h777777777777777777, 5'd0,  5'd1,  5'd2 },
    {1'b0, 72'h393333393333393393, 5'd1,  5'd4,  5'd10},
    {1'b1, 72'hFF0000000600005005, 5'd8,  5'd0,  5'd31},
    {1'b0, 72'hFF0000000600005005, 5'd16, 5'd17, 5'd8 },
    {1'b0, 72'h00000000A000000C00, 5'd2,  5'd9,  5'd31},
    {1'b1, 72'h0F0000000000000000, 5'd31, 5'd31, 5'd31},
    {1'b1, 72'h777777777777777777, 5'd0,  5'd1,  5'd31},
    {1'b0, 72'hF00000000000000000, 5'd17, 5'd31, 5'd31}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R3", "R4", "R4", "R8",
                                  "R8", "R5", "R8", "R8", "R3"};

  logic                  clk = 1'b0;
  logic                  rst, frame_first, reduced_mode;
  logic [NTOT*FW-1:0]    cand_frames;
  logic [NOUT*FW-1:0]    link_frames;
  logic                  link_first;
  logic [NTOT-1:0]       win_bits;

  best3_sorter #(.NSRC(NSRC), .NCAND(NCAND), .FRAME_W(FW), .QUAL_W(QW), .NOUT(NOUT)) u0 (
    .clk(clk), .rst(rst), .frame_first(frame_first), .reduced_mode(reduced_mode),
    .cand_frames(cand_frames), .link_frames(link_frames), .link_first(link_first),
    .win_bits(win_bits)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0]   cw [NTOT];
  logic [95:0]   pa_w, pb_w, cur_w;
  logic [17:0]   pa_m, pb_m, cur_m;
  string         pa_t, pb_t, cur_t;
  bit            pa_v, pb_v;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] vq(int v, int i);
    return VEC[v][15 + 4*i +: 4];
  endfunction

  function automatic logic [31:0] mkword(int v, int i, logic [3:0] q);
    return {q, 4'(i % 2), 8'(i + 16*v), 16'(32'h5A00 + v*37 + i*101)};
  endfunction

  task automatic fill_words(int v);
    for (int i = 0; i < NTOT; i++) cw[i] = (v < 0) ? 32'h0 : mkword(v, i, vq(v, i));
  endtask

  task automatic build_exp(int v);
    cur_w = '0; cur_m = '0;
    for (int s = 0; s < NOUT; s++) begin
      int e;
      e = int'(VEC[v][14 - 5*s -: 5]);
      if (e != 31) begin
        cur_w[s*32 +: 32] = cw[e];
        cur_m[e] = 1'b1;
      end
    end
  endtask

  task automatic drive_half(bit hi);
    frame_first = hi;
    for (int i = 0; i < NTOT; i++)
      cand_frames[i*FW +: FW] = hi ? cw[i][31:16] : cw[i][15:0];
  endtask

  task automatic check_all_zero(string req);
    check(req, 64'(link_first), 64'd0);
    check(req, 64'(link_frames), 64'd0);
    check(req, 64'(win_bits), 64'd0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 60000);
    checks++; fails++;
    $display("FAIL R9 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; frame_first = 1'b0; reduced_mode = 1'b0; cand_frames = '0;
    repeat (3) @(negedge clk);
    check_all_zero("R10 reset state");
    rst = 1'b0;
    pa_v = 0; pb_v = 0; pa_w = '0; pb_w = '0; pa_m = '0; pb_m = '0; pa_t = ""; pb_t = "";

    // table walk, crossings back to back (R9)
    for (int n = 0; n < NV + 2; n++) begin
      @(negedge clk);
      if (pb_v) begin
        check({"R6 link_first high ", pb_t}, 64'(link_first), 64'd1);
        for (int s = 0; s < NOUT; s++)
          check((pb_w[s*32 +: 32] == 0) ? "R5 empty slot hi" : "R3 slot hi",
                64'(link_frames[s*FW +: FW]), 64'(pb_w[s*32 + 16 +: 16]));
        check({"R7 mask ", pb_t}, 64'(win_bits), 64'(pb_m));
      end
      if (n < NV) begin
        fill_words(n);
        reduced_mode = VEC[n][87];
        build_exp(n);
        cur_t = VTAG[n];
      end else begin
        fill_words(-1);
        reduced_mode = 1'b0;
        cur_w = '0; cur_m = '0; cur_t = "R9";
      end
      drive_half(1'b1);
      @(negedge clk);
      if (pb_v) begin
        check({"R6 link_first low ", pb_t}, 64'(link_first), 64'd0);
        for (int s = 0; s < NOUT; s++)
          check((pb_w[s*32 +: 32] == 0) ? "R5 empty slot lo" : "R1 slot lo",
                64'(link_frames[s*FW +: FW]), 64'(pb_w[s*32 +: 16]));
      end
      drive_half(1'b0);
      pb_v = pa_v; pb_w = pa_w; pb_m = pa_m; pb_t = pa_t;
      pa_v = 1'b1; pa_w = cur_w; pa_m = cur_m; pa_t = cur_t;
    end
    @(negedge clk);
    frame_first = 1'b0; cand_frames = '0;
    repeat (4) @(negedge clk);

    // isolated crossing: exact latency and mask hold
    fill_words(2); reduced_mode = 1'b0; build_exp(2);
    drive_half(1'b1);
    @(negedge clk); drive_half(1'b0);
    @(negedge clk); frame_first = 1'b0; cand_frames = '0;
    check("R6 not yet at +2", 64'(link_first), 64'd0);
    @(negedge clk);
    check("R6 not yet at +3", 64'(link_first), 64'd0);
    @(negedge clk);
    check("R6 high at +4", 64'(link_first), 64'd1);
    check("R3 isolated slot0 hi", 64'(link_frames[FW-1:0]), 64'(cur_w[31:16]));
    @(negedge clk);
    check("R1 isolated slot2 lo", 64'(link_frames[2*FW +: FW]), 64'(cur_w[64 +: 16]));
    repeat (2) @(negedge clk);
    check("R7 mask held", 64'(win_bits), 64'(cur_m));
    check("R6 no spurious frame", 64'(link_first), 64'd0);

    // reset with a crossing in flight
    fill_words(3); build_exp(3);
    drive_half(1'b1);
    @(negedge clk); drive_half(1'b0);
    @(negedge clk); frame_first = 1'b0; cand_frames = '0; rst = 1'b1;
    @(negedge clk);
    check_all_zero("R10 reset in flight");
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R10 crossing discarded", 64'(link_first), 64'd0);
    end

    summary();
    $finish;
  end
endmodule